// File: doc/BRIEF.md
# Flash Program/Erase Status Tracker

This block is the status half of the write controller inside a flash memory. It keeps an eight-bit status byte that software polls while a word program or a block erase runs. It also drives a ready line that mirrors the top bit of that byte.

Commands arrive as a one-cycle strobe with a three-bit code. The block starts an operation and accepts suspend and resume requests. It aborts when the target block is locked or when the programming supply is low, and it reports a command sequence error with a combined code. Verify outcomes come in from outside as a valid/pass pair. For erase, the block counts the failed pulses and gives up after a set number. Error flags remain set until the clear command is given.

Top module: `flash_status_tracker`

## Requirements
- R1: After reset the status byte reads 0x80 and `ready` is 1.
- R2: An accepted program (code 1) or erase (code 2) drives status bit 7 and `ready` to 0 on the next cycle. Acceptance needs the block to be ready with no suspended operation, `blockLocked` low and `supplyOk` high.
- R3: A suspend (code 3) during a program sets bits 7 and 2 on the next cycle. Bit 2 holds until a resume (code 4), which clears it and makes the block busy again.
- R4: A suspend during an erase sets bits 7 and 6 on the next cycle. Bit 6 holds until a resume, and the failed-pulse count survives the suspension.
- R5: Each failed erase verify consumes one pulse. When the MAX_PULSES-th pulse fails, bit 5 is set and bit 7 returns to 1. If a verify passes earlier, the erase completes with no error bit.
- R6: A failed program verify sets bit 4 and returns bit 7 to 1.
- R7: If `supplyOk` is low when a program or erase command arrives, or when a verify result arrives, bit 3 is set and the block is ready again at once. In the first case it never goes busy.
- R8: A program or erase issued while `blockLocked` is high sets bit 1 and leaves the block ready. No busy cycle occurs.
- R9: A sequence-error code (6) issued while ready sets bits 7, 5 and 4 together. While busy the code is ignored.
- R10: Bits 5, 4, 3 and 1 are sticky across new operations. Only the clear code (5) resets them, and it leaves bits 7, 6 and 2 untouched.
- R11: Bit 0 always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdValid | input | 1 | One-cycle command strobe |
| cmdCode | input | 3 | Command code: 1 program, 2 erase, 3 suspend, 4 resume, 5 clear, 6 sequence error; others no-op |
| supplyOk | input | 1 | High when the programming supply is adequate |
| blockLocked | input | 1 | High when the addressed block is locked |
| verifyValid | input | 1 | Strobe carrying a verify result for the running operation |
| verifyPass | input | 1 | Verify outcome, 1 = pass |
| statusByte | output | 8 | Status byte: 7 ready, 6 erase suspended, 5 erase error, 4 program error, 3 supply abort, 2 program suspended, 1 lock abort, 0 zero |
| ready | output | 1 | Ready (1) or busy (0) |

## Verification
The assertions assume three things about the inputs. A verify strobe comes only while an operation is running, never in the same cycle as a command. A command strobe lasts one cycle. Under these conditions, the properties for suspend hold, lock abort and sticky errors can reason from the status byte alone. The stimulus keeps each command and each verify result in its own cycle, with idle gaps between them. It changes `supplyOk` and `blockLocked` only around the command or verify they are meant to affect.

// File: rtl/flash_status_pkg.sv
package flash_status_pkg;

  typedef enum logic [2:0] {
    CMD_NONE    = 3'd0,
    CMD_PROG    = 3'd1,
    CMD_ERASE   = 3'd2,
    CMD_SUSPEND = 3'd3,
    CMD_RESUME  = 3'd4,
    CMD_CLEAR   = 3'd5,
    CMD_SEQERR  = 3'd6,
    CMD_RSVD    = 3'd7
  } cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PROG,
    ST_ERASE,
    ST_PSUSP,
    ST_ESUSP
  } wsm_state_e;

  typedef struct packed {
    logic goBusy;
    logic goReady;
    logic setProgSusp;
    logic clrProgSusp;
    logic setEraseSusp;
    logic clrEraseSusp;
    logic setEraseErr;
    logic setProgErr;
    logic setSupplyErr;
    logic setLockErr;
    logic clearErr;
  } status_strobe_t;

endpackage

// File: rtl/flash_status_ctrl.sv
module flash_status_ctrl
  import flash_status_pkg::*;
#(
  parameter int MAX_PULSES = 8
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           cmdValid,
  input  logic [2:0]     cmdCode,
  input  logic           supplyOk,
  input  logic           blockLocked,
  input  logic           verifyValid,
  input  logic           verifyPass,
  output status_strobe_t stb
);

  localparam int PW = $clog2(MAX_PULSES + 1);
  localparam logic [PW-1:0] LAST_PULSE = PW'(MAX_PULSES - 1);

  wsm_state_e stateQ, stateD;
  logic [PW-1:0] pulseQ, pulseD;
  cmd_e cmd;

  assign cmd = cmd_e'(cmdCode);

  always_comb begin
    stb    = '0;
    stateD = stateQ;
    pulseD = pulseQ;
    if (cmdValid && cmd == CMD_CLEAR) begin
      stb.clearErr = 1'b1;
    end else begin
      unique case (stateQ)
        ST_IDLE: begin
          if (cmdValid && (cmd == CMD_PROG || cmd == CMD_ERASE)) begin
            if (blockLocked) begin
              stb.setLockErr = 1'b1;
            end else if (!supplyOk) begin
              stb.setSupplyErr = 1'b1;
            end else begin
              stb.goBusy = 1'b1;
              stateD     = (cmd == CMD_PROG) ? ST_PROG : ST_ERASE;
              pulseD     = '0;
            end
          end else if (cmdValid && cmd == CMD_SEQERR) begin
            stb.setEraseErr = 1'b1;
            stb.setProgErr  = 1'b1;
          end
        end
        ST_PROG: begin
          if (cmdValid && cmd == CMD_SUSPEND) begin
            stb.setProgSusp = 1'b1;
            stateD          = ST_PSUSP;
          end else if (verifyValid) begin
            stb.goReady = 1'b1;
            stateD      = ST_IDLE;
            if (!supplyOk)        stb.setSupplyErr = 1'b1;
            else if (!verifyPass) stb.setProgErr   = 1'b1;
          end
        end
        ST_ERASE: begin
          if (cmdValid && cmd == CMD_SUSPEND) begin
            stb.setEraseSusp = 1'b1;
            stateD           = ST_ESUSP;
          end else if (verifyValid) begin
            if (!supplyOk) begin
              stb.setSupplyErr = 1'b1;
              stb.goReady      = 1'b1;
              stateD           = ST_IDLE;
            end else if (verifyPass) begin
              stb.goReady = 1'b1;
              stateD      = ST_IDLE;
            end else if (pulseQ == LAST_PULSE) begin
              stb.setEraseErr = 1'b1;
              stb.goReady     = 1'b1;
              stateD          = ST_IDLE;
            end else begin
              pulseD = pulseQ + 1'b1;
            end
          end
        end
        ST_PSUSP: begin
          if (cmdValid && cmd == CMD_RESUME) begin
            stb.clrProgSusp = 1'b1;
            stb.goBusy      = 1'b1;
            stateD          = ST_PROG;
          end else if (cmdValid && cmd == CMD_SEQERR) begin
            stb.setEraseErr = 1'b1;
            stb.setProgErr  = 1'b1;
          end
        end
        ST_ESUSP: begin
          if (cmdValid && cmd == CMD_RESUME) begin
            stb.clrEraseSusp = 1'b1;
            stb.goBusy       = 1'b1;
            stateD           = ST_ERASE;
          end else if (cmdValid && cmd == CMD_SEQERR) begin
            stb.setEraseErr = 1'b1;
            stb.setProgErr  = 1'b1;
          end
        end
        default: stateD = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      pulseQ <= '0;
    end else begin
      stateQ <= stateD;
      pulseQ <= pulseD;
    end
  end

endmodule

// File: rtl/flash_status_dp.sv
module flash_status_dp
  import flash_status_pkg::*;
(
  input  logic           clk,
  input  logic           rstN,
  input  status_strobe_t stb,
  output logic [7:0]     statusByte
);

  logic readyQ, eraseSuspQ, progSuspQ;
  logic eraseErrQ, progErrQ, supplyErrQ, lockErrQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      readyQ      <= 1'b1;
      eraseSuspQ  <= 1'b0;
      progSuspQ   <= 1'b0;
      eraseErrQ   <= 1'b0;
      progErrQ    <= 1'b0;
      supplyErrQ  <= 1'b0;
      lockErrQ    <= 1'b0;
    end else begin
      if (stb.goBusy)
        readyQ <= 1'b0;
      else if (stb.goReady || stb.setProgSusp || stb.setEraseSusp)
        readyQ <= 1'b1;

      if (stb.setProgSusp)       progSuspQ <= 1'b1;
      else if (stb.clrProgSusp)  progSuspQ <= 1'b0;

      if (stb.setEraseSusp)      eraseSuspQ <= 1'b1;
      else if (stb.clrEraseSusp) eraseSuspQ <= 1'b0;

      if (stb.clearErr) begin
        eraseErrQ  <= 1'b0;
        progErrQ   <= 1'b0;
        supplyErrQ <= 1'b0;
        lockErrQ   <= 1'b0;
      end else begin
        if (stb.setEraseErr)  eraseErrQ  <= 1'b1;
        if (stb.setProgErr)   progErrQ   <= 1'b1;
        if (stb.setSupplyErr) supplyErrQ <= 1'b1;
        if (stb.setLockErr)   lockErrQ   <= 1'b1;
      end
    end
  end

  assign statusByte = {readyQ, eraseSuspQ, eraseErrQ, progErrQ,
                       supplyErrQ, progSuspQ, lockErrQ, 1'b0};

endmodule

// File: rtl/flash_status_tracker.sv
module flash_status_tracker
  import flash_status_pkg::*;
#(
  parameter int MAX_PULSES = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  logic [2:0] cmdCode,
  input  logic       supplyOk,
  input  logic       blockLocked,
  input  logic       verifyValid,
  input  logic       verifyPass,
  output logic [7:0] statusByte,
  output logic       ready
);

  status_strobe_t stb;

  flash_status_ctrl #(.MAX_PULSES(MAX_PULSES)) i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .cmdValid   (cmdValid),
    .cmdCode    (cmdCode),
    .supplyOk   (supplyOk),
    .blockLocked(blockLocked),
    .verifyValid(verifyValid),
    .verifyPass (verifyPass),
    .stb        (stb)
  );

  flash_status_dp i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .statusByte(statusByte)
  );

  assign ready = statusByte[7];

endmodule

// File: rtl/flash_status_chk.sv
module flash_status_chk (
  input logic       clk,
  input logic       rstN,
  input logic       cmdValid,
  input logic [2:0] cmdCode,
  input logic       supplyOk,
  input logic       blockLocked,
  input logic [7:0] statusByte,
  input logic       ready
);

  logic idleReady;
  assign idleReady = statusByte[7] && !statusByte[6] && !statusByte[2];

  // R11
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !statusByte[0]);

  // R2
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && (cmdCode == 3'd1 || cmdCode == 3'd2) && idleReady &&
     !blockLocked && supplyOk) |=> (!statusByte[7] && !ready));

  // R3
  prog_susp_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (statusByte[2] && !(cmdValid && cmdCode == 3'd4)) |=> (statusByte[2] && statusByte[7]));

  // R4
  erase_susp_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (statusByte[6] && !(cmdValid && cmdCode == 3'd4)) |=> (statusByte[6] && statusByte[7]));

  // R8
  lock_abort_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && (cmdCode == 3'd1 || cmdCode == 3'd2) && idleReady && blockLocked)
      |=> (statusByte[7] && statusByte[1]));

  // R10
  sticky_erase_err_chk: assert property (@(posedge clk) disable iff (!rstN)
    (statusByte[5] && !(cmdValid && cmdCode == 3'd5)) |=> statusByte[5]);

  // R10
  sticky_lock_err_chk: assert property (@(posedge clk) disable iff (!rstN)
    (statusByte[1] && !(cmdValid && cmdCode == 3'd5)) |=> statusByte[1]);

  // R10
  clear_errs_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdCode == 3'd5) |=> (statusByte[5:3] == 3'b000 && !statusByte[1]));

endmodule

bind flash_status_tracker flash_status_chk i_chk (
  .clk        (clk),
  .rstN       (rstN),
  .cmdValid   (cmdValid),
  .cmdCode    (cmdCode),
  .supplyOk   (supplyOk),
  .blockLocked(blockLocked),
  .statusByte (statusByte),
  .ready      (ready)
);

// File: tb/test_flash_status_tracker.sv
module test_flash_status_tracker;

  localparam int MAXP = 8;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cmdValid = 1'b0;
  logic [2:0] cmdCode = 3'd0;
  logic       supplyOk = 1'b1;
  logic       blockLocked = 1'b0;
  logic       verifyValid = 1'b0;
  logic       verifyPass = 1'b0;
  logic [7:0] statusByte;
  logic       ready;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit finished = 0;

  // reference model state
  logic [7:0] mSr = 8'h80;
  int mMode = 0;   // 0 none, 1 program, 2 erase
  int mPulses = 0;

  always #4 clk = ~clk;

  flash_status_tracker #(.MAX_PULSES(MAXP)) i_flash_status_tracker (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdCode(cmdCode),
    .supplyOk(supplyOk), .blockLocked(blockLocked),
    .verifyValid(verifyValid), .verifyPass(verifyPass),
    .statusByte(statusByte), .ready(ready)
  );

  // behavioural reference, evaluated on each rising edge
  always @(posedge clk) begin
    if (!rstN) begin
      mSr = 8'h80; mMode = 0; mPulses = 0;
    end else if (cmdValid && cmdCode == 3'd5) begin
      mSr = mSr & 8'b1100_0101;
    end else if (cmdValid && (cmdCode == 3'd1 || cmdCode == 3'd2) && mMode == 0) begin
      if (blockLocked) mSr[1] = 1'b1;
      else if (!supplyOk) mSr[3] = 1'b1;
      else begin
        mMode = (cmdCode == 3'd1) ? 1 : 2;
        mPulses = 0;
        mSr[7] = 1'b0;
      end
    end else if (cmdValid && cmdCode == 3'd3 && !mSr[7]) begin
      mSr[7] = 1'b1;
      if (mMode == 1) mSr[2] = 1'b1; else mSr[6] = 1'b1;
    end else if (cmdValid && cmdCode == 3'd4 && (mSr[2] || mSr[6])) begin
      mSr[2] = 1'b0; mSr[6] = 1'b0; mSr[7] = 1'b0;
    end else if (cmdValid && cmdCode == 3'd6 && mSr[7]) begin
      mSr[5] = 1'b1; mSr[4] = 1'b1;
    end else if (!cmdValid && verifyValid && !mSr[7]) begin
      if (!supplyOk) begin
        mSr[3] = 1'b1; mSr[7] = 1'b1; mMode = 0;
      end else if (verifyPass) begin
        mSr[7] = 1'b1; mMode = 0;
      end else if (mMode == 1) begin
        mSr[4] = 1'b1; mSr[7] = 1'b1; mMode = 0;
      end else begin
        mPulses++;
        if (mPulses >= MAXP) begin
          mSr[5] = 1'b1; mSr[7] = 1'b1; mMode = 0;
        end
      end
    end
  end

  // per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    cycles++;
    if (rstN && !finished) begin
      checks++;
      if (statusByte !== mSr || ready !== mSr[7]) begin
        fails++;
        $display("FAIL model R2 cycle %0d: status=%h ready=%b expected status=%h ready=%b",
                 cycles, statusByte, ready, mSr, mSr[7]);
      end
    end
    if (cycles > 20000 && !finished) begin
      fails++;
      $display("FAIL watchdog R1: cycles=%0d expected completion", cycles);
      summary();
    end
  end

  task automatic summary();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  task automatic expect_sr(input logic [7:0] exp, input string tag);
    checks++;
    if (statusByte !== exp || ready !== exp[7]) begin
      fails++;
      $display("FAIL %s: status=%h ready=%b expected status=%h ready=%b",
               tag, statusByte, ready, exp, exp[7]);
    end
  endtask

  task automatic issue(input logic [2:0] code);
    @(negedge clk);
    cmdValid = 1'b1; cmdCode = code;
    @(negedge clk);
    cmdValid = 1'b0; cmdCode = 3'd0;
  endtask

  task automatic verify(input logic pass);
    @(negedge clk);
    verifyValid = 1'b1; verifyPass = pass;
    @(negedge clk);
    verifyValid = 1'b0; verifyPass = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    idle(3);
    rstN = 1'b1;
    idle(1);
    expect_sr(8'h80, "R1 reset");
    expect_sr(8'h80, "R11 bit0 zero after reset");

    // program passes
    issue(3'd1);
    expect_sr(8'h00, "R2 program busy");
    idle(2);
    verify(1'b1);
    expect_sr(8'h80, "R2 program done");

    // program fails
    issue(3'd1);
    verify(1'b0);
    expect_sr(8'h90, "R6 program error");
    issue(3'd5);
    expect_sr(8'h80, "R10 clear");

    // erase passes after some failed pulses
    issue(3'd2);
    for (int i = 0; i < 3; i++) verify(1'b0);
    expect_sr(8'h00, "R5 erase still busy");
    verify(1'b1);
    expect_sr(8'h80, "R5 erase success");

    // erase exhausts its pulses
    issue(3'd2);
    for (int i = 0; i < MAXP - 1; i++) verify(1'b0);
    expect_sr(8'h00, "R5 busy before last pulse");
    verify(1'b0);
    expect_sr(8'hA0, "R5 retry exhausted");

    // sticky across a new operation
    issue(3'd1);
    expect_sr(8'h20, "R10 sticky while busy");
    verify(1'b1);
    expect_sr(8'hA0, "R10 sticky after completion");
    issue(3'd5);
    expect_sr(8'h80, "R10 clear erase error");

    // low supply at acceptance and at verify
    supplyOk = 1'b0;
    issue(3'd2);
    supplyOk = 1'b1;
    expect_sr(8'h88, "R7 low supply at accept");
    issue(3'd5);
    issue(3'd1);
    supplyOk = 1'b0;
    verify(1'b1);
    supplyOk = 1'b1;
    expect_sr(8'h88, "R7 low supply at verify");
    issue(3'd5);

    // locked block
    blockLocked = 1'b1;
    issue(3'd1);
    expect_sr(8'h82, "R8 locked program");
    issue(3'd2);
    blockLocked = 1'b0;
    expect_sr(8'h82, "R8 locked erase");
    issue(3'd5);
    expect_sr(8'h80, "R10 clear lock error");

    // program suspend and resume
    issue(3'd1);
    issue(3'd3);
    expect_sr(8'h84, "R3 program suspended");
    idle(4);
    issue(3'd2);
    expect_sr(8'h84, "R3 erase ignored while suspended");
    issue(3'd5);
    expect_sr(8'h84, "R10 clear keeps suspend bit");
    issue(3'd4);
    expect_sr(8'h00, "R3 program resumed");
    verify(1'b1);
    expect_sr(8'h80, "R3 program completed");

    // erase suspend keeps pulse count
    issue(3'd2);
    verify(1'b0);
    issue(3'd3);
    expect_sr(8'hC0, "R4 erase suspended");
    idle(3);
    issue(3'd4);
    expect_sr(8'h00, "R4 erase resumed");
    for (int i = 0; i < MAXP - 2; i++) verify(1'b0);
    expect_sr(8'h00, "R4 count kept, still busy");
    verify(1'b0);
    expect_sr(8'hA0, "R4 count kept across suspend");
    issue(3'd5);

    // sequence error
    issue(3'd6);
    expect_sr(8'hB0, "R9 sequence error");
    issue(3'd5);
    issue(3'd1);
    issue(3'd6);
    expect_sr(8'h00, "R9 ignored while busy");
    verify(1'b1);
    expect_sr(8'h80, "R11 bit0 zero at end");

    idle(2);
    summary();
  end

endmodule